// File: doc/BRIEF.md
# Page-Aware Memory Request Scheduler

This block collects memory read and write requests from four requestors: two processor bus ports, a PCI port and an AGP port. It parks them in a pool of eight entries and hands one request per cycle to a downstream DRAM controller over a valid/ready handshake. Because every memory request passes through here, the order in which requests leave this block is the memory ordering that the rest of the system sees.

The pick is made in three levels. First come entries that have waited long enough to count as starved. Next come entries whose row is already open in their bank. Last come all remaining eligible entries. Within each level the entry that arrived first wins. A request that targets the same bank, row and column as an older pending entry is held back until that entry has gone. When the pool is empty, an arriving request is presented to the controller in the same cycle, with no arbitration step. The block does not model DRAM timing, data transfer or snooping.

Each requestor owns two of the eight slots. A per-source full flag tells that requestor when its new requests would be dropped.

Top module: `mem_req_sched`

## Requirements
- R1: After reset, memValid and every srcFull bit are 0, and every bank is treated as having no open row, so a bank's first request counts as a page conflict.
- R2: When the pool is empty and at least one source presents a request, memValid rises in the same cycle and carries the request of the lowest-numbered presenting source (source 0 = bus port 0, 1 = bus port 1, 2 = PCI, 3 = AGP). If memReady is high in that cycle, the request is not stored.
- R3: Each source owns two slots. srcFull[s] is 1 exactly when both of source s's slots are occupied. A request presented while srcFull[s] is 1 is dropped and is never issued.
- R4: Among eligible entries that are not starved, an entry whose row equals the open row of its bank is issued before an entry that would cause a page conflict.
- R5: If no eligible entry is starved or a page hit, the eligible entry that arrived first is issued.
- R6: Each stored entry's 4-bit age starts at 0 and rises by one for each clock edge it stays in the pool, saturating at 15. An entry whose age is 12 or more is starved and wins over any page hit. Among starved entries the oldest wins.
- R7: An entry whose bank, row and column equal those of an older pending entry is never issued before that older entry, whether each is a read or a write.
- R8: An entry leaves the pool only on a cycle where memValid and memReady are both 1. While memReady is 0, pending requests are kept and memValid stays 1.
- R9: Every issued request, including one sent through the empty-pool path, makes its row the open row of its bank from the next cycle on.
- R10: Requests stored in the same cycle are ordered by source number, so the lower source counts as older.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 4 | Request present, one bit per source |
| reqWrite | input | 4 | 1 = write, 0 = read, per source |
| reqBank | input | 8 | Bank per source, 2 bits each, source 0 in the low bits |
| reqRow | input | 48 | Row per source, 12 bits each |
| reqCol | input | 40 | Column per source, 10 bits each |
| srcFull | output | 4 | Both slots of the source are occupied |
| memValid | output | 1 | A request is offered to the controller |
| memReady | input | 1 | Controller accepts the offered request |
| memSrc | output | 2 | Source number of the offered request |
| memWrite | output | 1 | 1 = write |
| memBank | output | 2 | Bank of the offered request |
| memRow | output | 12 | Row of the offered request |
| memCol | output | 10 | Column of the offered request |

## Verification
The offered request is a combinational function of the pool state and the current inputs. The bench therefore drives inputs on the falling edge and checks memValid and the offered fields 1 ns later, before the next rising edge. This applies both to the empty-pool pass-through and to each pool pick. A stored request, a freed slot, an age step and an open-row update all take effect at the next rising edge, so those effects are checked in the following cycle's window. A starvation win comes due in the thirteenth cycle after the waiting entry was stored, and the bench counts cycles to check that exact cycle.

// File: rtl/mrs_pkg.sv
`timescale 1ns/1ps
package mrs_pkg;
  parameter int NUM_SRC       = 4;
  parameter int SLOTS_PER_SRC = 2;
  parameter int NUM_SLOTS     = NUM_SRC * SLOTS_PER_SRC;
  parameter int NUM_BANKS     = 4;
  parameter int BANK_W        = $clog2(NUM_BANKS);
  parameter int ROW_W         = 12;
  parameter int COL_W         = 10;
  parameter int AGE_W         = 4;
  parameter int SRC_W         = $clog2(NUM_SRC);

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic              write;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } memReq_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_SLOTS-1:0] alloc;
    logic [NUM_SLOTS-1:0] grant;
    logic [NUM_SRC-1:0]   bypassSel;
    logic                 useBypass;
    logic                 fire;
  } schedStrobe_t;
endpackage

// File: rtl/mrs_datapath.sv
`timescale 1ns/1ps
module mrs_datapath
  import mrs_pkg::*;
#(
  parameter int STARVE_AGE = 12
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  memReq_t [NUM_SRC-1:0]               reqIn,
  input  schedStrobe_t                        strb,
  output logic [NUM_SLOTS-1:0]                slotValid,
  output logic [NUM_SLOTS-1:0]                starved,
  output logic [NUM_SLOTS-1:0]                pageHit,
  output logic [NUM_SLOTS-1:0]                blocked,
  output logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] olderThan,
  output memReq_t                             issueReq
);
  localparam logic [AGE_W-1:0] AGE_MAX    = '1;
  localparam logic [AGE_W-1:0] STARVE_LVL = AGE_W'(STARVE_AGE);

  memReq_t [NUM_SLOTS-1:0]    slotReq;
  logic [NUM_SLOTS-1:0][AGE_W-1:0] slotAge;
  logic [NUM_BANKS-1:0][ROW_W-1:0] openRow;
  logic [NUM_BANKS-1:0]       openVld;

  // slot storage, ages and arrival order
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      slotReq   <= '0;
      slotAge   <= '0;
      olderThan <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (strb.alloc[i]) begin
          slotValid[i] <= 1'b1;
          slotReq[i]   <= reqIn[i / SLOTS_PER_SRC];
          slotAge[i]   <= '0;
        end else if (strb.fire && strb.grant[i]) begin
          slotValid[i] <= 1'b0;
        end else if (slotValid[i] && slotAge[i] != AGE_MAX) begin
          slotAge[i] <= slotAge[i] + 1'b1;
        end
        for (int j = 0; j < NUM_SLOTS; j++) begin
          if (strb.alloc[i])
            olderThan[i][j] <= (slotValid[j] && !(strb.fire && strb.grant[j]))
                               || (strb.alloc[j] && (j < i));
          else
            olderThan[i][j] <= olderThan[i][j] && !strb.alloc[j];
        end
      end
    end
  end

  // open row per bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      openRow <= '0;
      openVld <= '0;
    end else if (strb.fire) begin
      openRow[issueReq.bank] <= issueReq.row;
      openVld[issueReq.bank] <= 1'b1;
    end
  end

  // per-slot flags
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      starved[i] = slotAge[i] >= STARVE_LVL;
      pageHit[i] = openVld[slotReq[i].bank] && (openRow[slotReq[i].bank] == slotReq[i].row);
      blocked[i] = 1'b0;
      for (int j = 0; j < NUM_SLOTS; j++) begin
        if (slotValid[j] && olderThan[i][j] &&
            slotReq[j].bank == slotReq[i].bank &&
            slotReq[j].row  == slotReq[i].row  &&
            slotReq[j].col  == slotReq[i].col)
          blocked[i] = 1'b1;
      end
    end
  end

  // issue mux: pass-through or pool winner
  always_comb begin
    issueReq = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (strb.useBypass && strb.bypassSel[s])
        issueReq = issueReq | reqIn[s];
    for (int i = 0; i < NUM_SLOTS; i++)
      if (!strb.useBypass && strb.grant[i])
        issueReq = issueReq | slotReq[i];
  end

  AST_NO_ALLOC_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.alloc & slotValid) == '0); // R3

  AST_OPEN_ROW: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> openRow[$past(issueReq.bank)] == $past(issueReq.row)); // R9

  AST_KEEP_UNFIRED: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.fire && slotValid != '0) |=> (slotValid & $past(slotValid)) == $past(slotValid)); // R8

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_ageChk
    AST_AGE_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (slotValid[g] && !(strb.fire && strb.grant[g]) && slotAge[g] != AGE_MAX)
      |=> slotAge[g] == $past(slotAge[g]) + 1'b1); // R6
    AST_AGE_SAT: assert property (@(posedge clk) disable iff (!rstN)
      (slotValid[g] && !(strb.fire && strb.grant[g]) && slotAge[g] == AGE_MAX)
      |=> slotAge[g] == AGE_MAX); // R6
  end
endmodule

// File: rtl/mrs_control.sv
`timescale 1ns/1ps
module mrs_control
  import mrs_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_SRC-1:0]                  reqValid,
  input  logic                                memReady,
  input  logic [NUM_SLOTS-1:0]                slotValid,
  input  logic [NUM_SLOTS-1:0]                starved,
  input  logic [NUM_SLOTS-1:0]                pageHit,
  input  logic [NUM_SLOTS-1:0]                blocked,
  input  logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] olderThan,
  output schedStrobe_t                        strb,
  output logic                                memValid,
  output logic [NUM_SRC-1:0]                  srcFull
);
  logic                 poolBusy;
  logic [NUM_SLOTS-1:0] eligible, starvedSet, hitSet, pickSet, grantVec;
  logic                 found;

  always_comb begin
    poolBusy   = |slotValid;
    eligible   = slotValid & ~blocked;
    starvedSet = eligible & starved;
    hitSet     = eligible & pageHit;
    if (starvedSet != '0)      pickSet = starvedSet;
    else if (hitSet != '0)     pickSet = hitSet;
    else                       pickSet = eligible;
    for (int i = 0; i < NUM_SLOTS; i++)
      grantVec[i] = pickSet[i] && ((pickSet & olderThan[i]) == '0);
  end

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++)
      srcFull[s] = &slotValid[s*SLOTS_PER_SRC +: SLOTS_PER_SRC];
  end

  always_comb begin
    strb  = '0;
    found = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (!poolBusy && reqValid[s] && !found) begin
        strb.bypassSel[s] = 1'b1;
        found = 1'b1;
      end
    end
    strb.useBypass = !poolBusy && (reqValid != '0);
    memValid       = poolBusy || strb.useBypass;
    strb.fire      = memValid && memReady;
    strb.grant     = poolBusy ? grantVec : '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      logic take, placed;
      take   = reqValid[s] && !srcFull[s] && !(strb.bypassSel[s] && strb.fire);
      placed = 1'b0;
      for (int k = 0; k < SLOTS_PER_SRC; k++) begin
        if (take && !placed && !slotValid[s*SLOTS_PER_SRC + k]) begin
          strb.alloc[s*SLOTS_PER_SRC + k] = 1'b1;
          placed = 1'b1;
        end
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid != '0) |-> $countones(strb.grant) == 1); // R5

  AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.useBypass |-> slotValid == '0); // R2

  AST_STARVED_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ((slotValid & starved & ~blocked) != '0) |-> (strb.grant & starved) != '0); // R6

  AST_HIT_PREF: assert property (@(posedge clk) disable iff (!rstN)
    ((slotValid & ~blocked & starved) == '0 && (slotValid & ~blocked & pageHit) != '0)
    |-> (strb.grant & pageHit) != '0); // R4

  AST_NO_BLOCKED_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.grant & blocked) == '0); // R7

  AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
    (srcFull == '1) |-> strb.alloc == '0); // R3
endmodule

// File: rtl/mem_req_sched.sv
`timescale 1ns/1ps
module mem_req_sched
  import mrs_pkg::*;
#(
  parameter int STARVE_AGE = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         reqValid,
  input  logic [NUM_SRC-1:0]         reqWrite,
  input  logic [NUM_SRC*BANK_W-1:0]  reqBank,
  input  logic [NUM_SRC*ROW_W-1:0]   reqRow,
  input  logic [NUM_SRC*COL_W-1:0]   reqCol,
  output logic [NUM_SRC-1:0]         srcFull,
  output logic                       memValid,
  input  logic                       memReady,
  output logic [SRC_W-1:0]           memSrc,
  output logic                       memWrite,
  output logic [BANK_W-1:0]          memBank,
  output logic [ROW_W-1:0]           memRow,
  output logic [COL_W-1:0]           memCol
);
  memReq_t [NUM_SRC-1:0]                reqIn;
  schedStrobe_t                         strb;
  logic [NUM_SLOTS-1:0]                 slotValid, starved, pageHit, blocked;
  logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0]  olderThan;
  memReq_t                              issueReq;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_pack
    assign reqIn[s].src   = SRC_W'(s);
    assign reqIn[s].write = reqWrite[s];
    assign reqIn[s].bank  = reqBank[s*BANK_W +: BANK_W];
    assign reqIn[s].row   = reqRow[s*ROW_W +: ROW_W];
    assign reqIn[s].col   = reqCol[s*COL_W +: COL_W];
  end

  mrs_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReady(memReady),
    .slotValid(slotValid), .starved(starved), .pageHit(pageHit),
    .blocked(blocked), .olderThan(olderThan), .strb(strb),
    .memValid(memValid), .srcFull(srcFull)
  );

  mrs_datapath #(.STARVE_AGE(STARVE_AGE)) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .strb(strb),
    .slotValid(slotValid), .starved(starved), .pageHit(pageHit),
    .blocked(blocked), .olderThan(olderThan), .issueReq(issueReq)
  );

  assign memSrc   = issueReq.src;
  assign memWrite = issueReq.write;
  assign memBank  = issueReq.bank;
  assign memRow   = issueReq.row;
  assign memCol   = issueReq.col;
endmodule

// File: tb/tb_mem_req_sched.sv
`timescale 1ns/1ps
module tb_mem_req_sched;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  reqValid, reqWrite;
  logic [7:0]  reqBank;
  logic [47:0] reqRow;
  logic [39:0] reqCol;
  logic [3:0]  srcFull;
  logic        memValid, memReady, memWrite;
  logic [1:0]  memSrc, memBank;
  logic [11:0] memRow;
  logic [9:0]  memCol;
  int          nChecks = 0, nFails = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  mem_req_sched dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .srcFull(srcFull),
    .memValid(memValid), .memReady(memReady), .memSrc(memSrc),
    .memWrite(memWrite), .memBank(memBank), .memRow(memRow), .memCol(memCol)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        vld;
    logic [1:0]  src;
    logic        wr;
    logic [1:0]  bank;
    logic [11:0] row;
    logic [9:0]  col;
    logic        rdy;
    logic        expV;
    logic [1:0]  expSrc;
    logic [11:0] expRow;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b1, 2'd0, 1'b0, 2'd0, 12'h010, 10'd1, 1'b1, 1'b1, 2'd0, 12'h010}, // R2 pass-through
    '{4'd2, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000, 10'd0, 1'b1, 1'b0, 2'd0, 12'h000}, // R2 not stored
    '{4'd8, 1'b1, 2'd1, 1'b0, 2'd0, 12'h020, 10'd2, 1'b0, 1'b1, 2'd1, 12'h020}, // R8 offered, held
    '{4'd8, 1'b1, 2'd2, 1'b0, 2'd0, 12'h010, 10'd3, 1'b0, 1'b1, 2'd1, 12'h020}, // R8 still offered
    '{4'd9, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000, 10'd0, 1'b1, 1'b1, 2'd2, 12'h010}, // R9 R4 hit wins
    '{4'd4, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000, 10'd0, 1'b1, 1'b1, 2'd1, 12'h020}, // R4 conflict last
    '{4'd2, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000, 10'd0, 1'b1, 1'b0, 2'd0, 12'h000}, // R2 idle
    '{4'd5, 1'b1, 2'd3, 1'b0, 2'd1, 12'h005, 10'd4, 1'b0, 1'b1, 2'd3, 12'h005}, // R5
    '{4'd5, 1'b1, 2'd0, 1'b1, 2'd2, 12'h006, 10'd5, 1'b0, 1'b1, 2'd3, 12'h005}, // R5
    '{4'd1, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000, 10'd0, 1'b1, 1'b1, 2'd3, 12'h005}, // R1 R5 closed banks, oldest
    '{4'd5, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000, 10'd0, 1'b1, 1'b1, 2'd0, 12'h006}, // R5
    '{4'd2, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000, 10'd0, 1'b1, 1'b0, 2'd0, 12'h000}  // R2 idle
  };

  task automatic clearReq();
    reqValid = '0; reqWrite = '0; reqBank = '0; reqRow = '0; reqCol = '0;
  endtask

  task automatic putReq(input int s, input bit wr, input int bank, input int row, input int col);
    reqValid[s] = 1'b1;
    reqWrite[s] = wr;
    reqBank[s*2 +: 2]  = 2'(bank);
    reqRow[s*12 +: 12] = 12'(row);
    reqCol[s*10 +: 10] = 10'(col);
  endtask

  task automatic chkBit(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic chkIssue(input string tag, input bit expV, input int expSrc, input int expRow);
    chkBit(tag, "memValid", int'(memValid), int'(expV));
    if (expV && memValid) begin
      chkBit(tag, "memSrc", int'(memSrc), expSrc);
      chkBit(tag, "memRow", int'(memRow), expRow);
    end
  endtask

  function automatic string tagOf(input int n);
    return $sformatf("R%0d", n);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    rstN = 1'b0; memReady = 1'b0; clearReq();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chkBit("R1", "memValid", int'(memValid), 0);
    chkBit("R1", "srcFull", int'(srcFull), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      clearReq();
      if (VECS[v].vld)
        putReq(VECS[v].src, VECS[v].wr, VECS[v].bank, VECS[v].row, VECS[v].col);
      memReady = VECS[v].rdy;
      #1;
      chkIssue(tagOf(VECS[v].req), VECS[v].expV, VECS[v].expSrc, VECS[v].expRow);
    end

    // R10 simultaneous arrivals, R2 lowest source passes through
    @(negedge clk); clearReq(); memReady = 1'b1;
    putReq(1, 0, 3, 'h100, 1); putReq(2, 0, 3, 'h200, 2); putReq(3, 0, 3, 'h300, 3);
    #1; chkIssue("R2", 1, 1, 'h100);
    @(negedge clk); clearReq(); #1; chkIssue("R10", 1, 2, 'h200);
    @(negedge clk); #1; chkIssue("R10", 1, 3, 'h300);
    @(negedge clk); #1; chkIssue("R10", 0, 0, 0);

    // R3 full source drops its request
    @(negedge clk); memReady = 1'b0; putReq(0, 0, 1, 'h031, 1); #1; chkIssue("R3", 1, 0, 'h031);
    @(negedge clk); putReq(0, 0, 1, 'h032, 2); #1; chkIssue("R3", 1, 0, 'h031);
    @(negedge clk); putReq(0, 0, 1, 'h033, 3); #1;
    chkBit("R3", "srcFull", int'(srcFull), 1);
    chkIssue("R8", 1, 0, 'h031);
    @(negedge clk); clearReq(); memReady = 1'b1; #1; chkIssue("R3", 1, 0, 'h031);
    @(negedge clk); #1; chkIssue("R3", 1, 0, 'h032);
    chkBit("R3", "srcFull", int'(srcFull), 0);
    @(negedge clk); #1; chkIssue("R3", 0, 0, 0);

    // R6 starvation beats a stream of page hits (bank 2 open at row 6)
    @(negedge clk); memReady = 1'b0; putReq(3, 0, 2, 'h007, 0); #1; chkIssue("R2", 1, 3, 'h007);
    @(negedge clk); clearReq(); putReq(0, 0, 2, 'h006, 1); putReq(1, 0, 2, 'h006, 2);
    #1; chkIssue("R8", 1, 3, 'h007);
    for (int k = 2; k <= 13; k++) begin
      @(negedge clk); clearReq(); memReady = 1'b1;
      putReq(0, 0, 2, 'h006, 16 + 2*k); putReq(1, 0, 2, 'h006, 17 + 2*k);
      #1;
      if (k < 13) begin
        chkBit("R4", "memRow", int'(memRow), 'h006);
      end else begin
        chkIssue("R6", 1, 3, 'h007);
      end
    end
    @(negedge clk); clearReq();
    for (int w = 0; w < 20 && memValid; w++) @(negedge clk);
    #1; chkIssue("R8", 0, 0, 0);

    // R7 same address order: write then read
    @(negedge clk); memReady = 1'b0; putReq(2, 1, 3, 'h055, 9); #1; chkIssue("R7", 1, 2, 'h055);
    @(negedge clk); clearReq(); putReq(0, 0, 3, 'h055, 9); #1; chkIssue("R7", 1, 2, 'h055);
    @(negedge clk); clearReq(); memReady = 1'b1; #1;
    chkIssue("R7", 1, 2, 'h055); chkBit("R7", "memWrite", int'(memWrite), 1);
    @(negedge clk); #1;
    chkIssue("R7", 1, 0, 'h055); chkBit("R7", "memWrite", int'(memWrite), 0);
    @(negedge clk); #1; chkIssue("R7", 0, 0, 0);

    summary();
  end
endmodule